// File: doc/BRIEF.md
# Transmit Frame Loader Sequencer

This block copies an outgoing payload from a byte buffer into the transmit memory of a radio transceiver and then starts the transmission. It does no bus signalling itself. It issues one register write at a time to a separate register access engine and waits for that engine to finish each write before it issues the next one.

A load begins with a one-cycle `start_i` pulse that carries the payload length. The block writes a fixed transmit-memory image in long address space:

- A header-length entry of zero.
- The payload length.
- Every payload byte, at consecutive addresses.

It then writes the value that fires transmission into one short-space register. The payload buffer is read through a synchronous read port, so the buffer can be a block RAM. When the final write is acknowledged, the block raises a one-cycle completion pulse. Building the frame header, addressing and checking transmit status belong to other blocks.

Top module: `tx_frame_loader`

## Requirements
- R1: During and directly after a synchronous active-high reset, `req_o`, `done_o` and `rd_addr_o` are all zero.
- R2: The first write of every load goes to long address 0x000 (`req_long_o`=1) with data 0x00.
- R3: The second write goes to long address 0x001 with the accepted payload length as data.
- R4: Payload byte i is written to long address 0x002+i, in ascending order of i. Its value is the buffer word at index i. The buffer port has a one-cycle read latency: data appears on `rd_data_i` the cycle after `rd_addr_o` is presented.
- R5: The last write of every load goes to short address 0x1B (`req_long_o`=0) with data 0x01.
- R6: A request is a level on `req_o`, and its space, address and data stay stable until `ack_i` is sampled high. In the cycle after that handshake `req_o` is low. The next request rises exactly three cycles after the handshake edge, and the first request of a load rises three cycles after the start edge.
- R7: `done_o` is high for exactly one cycle, the cycle after the trigger write's handshake, and at no other time.
- R8: A length of zero produces exactly three writes: the header entry, a length entry of 0, and the trigger.
- R9: `start_i` is ignored while a load is in progress. Neither the length nor the write stream of the running load changes.
- R10: A requested length above MAX_LEN is clamped to MAX_LEN. The clamped value is written as the length entry, and that many payload bytes follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a load (honoured only when idle) |
| len_i | input | LEN_W | Payload length in bytes, sampled with start_i |
| rd_addr_o | output | LEN_W | Payload buffer read index |
| rd_data_i | input | 8 | Payload buffer data, one cycle after rd_addr_o |
| req_o | output | 1 | Write request to the access engine (level) |
| req_long_o | output | 1 | 1 = long address space, 0 = short address space |
| req_addr_o | output | 10 | Register address of the write |
| req_data_o | output | 8 | Data byte of the write |
| ack_i | input | 1 | Access engine finished the current write |
| done_o | output | 1 | One-cycle pulse after the trigger write completes |

## Verification
The bench runs loads with the following lengths:

- Zero, which shows that the framing writes do not depend on payload.
- One and a few bytes, which exercise the boundary between the length entry and the first payload byte.
- The maximum, which checks the top of the address range.
- An oversize value, which separates clamping from truncation or wrap-around.

The engine's acknowledge delay is varied from zero to three cycles. This separates a design that waits for each handshake from one that runs on a fixed schedule. One load receives a second start carrying a different length while it is running, and one load is started in the same cycle as the previous completion pulse. Together these show whether busy-time starts are dropped and idle-time starts are taken at once.

// File: rtl/tfl_pkg.sv
package tfl_pkg;
  localparam int unsigned REG_ADDR_W   = 10;
  localparam int unsigned TRIG_ADDR    = 'h1B;
  localparam logic [7:0]  TRIG_VALUE   = 8'h01;
  localparam logic [7:0]  NO_HDR_BYTES = 8'h00;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FETCH,
    ST_LOAD,
    ST_WAIT
  } tfl_state_e;
endpackage

// File: rtl/tfl_step_decode.sv
// Maps a step number to the write it stands for:
// step 0 header entry, step 1 length, steps 2..len+1 payload, step len+2 trigger.
module tfl_step_decode
  import tfl_pkg::*;
#(
  parameter int unsigned LEN_W  = 7,
  parameter int unsigned STEP_W = 7
) (
  input  logic [STEP_W-1:0]     step_i,
  input  logic [LEN_W-1:0]      len_i,
  input  logic [7:0]            byte_i,
  output logic                  long_o,
  output logic [REG_ADDR_W-1:0] addr_o,
  output logic [7:0]            data_o,
  output logic                  last_o
);
  localparam int unsigned CW = STEP_W + 1;

  logic [CW-1:0] step_w;
  logic [CW-1:0] trig_step;

  assign step_w    = CW'(step_i);
  assign trig_step = CW'(len_i) + CW'(2);

  always_comb begin
    last_o = (step_w == trig_step);
    long_o = 1'b1;
    addr_o = REG_ADDR_W'(step_i);   // payload i sits at step i+2 = address 0x002+i
    data_o = byte_i;
    if (last_o) begin
      long_o = 1'b0;
      addr_o = REG_ADDR_W'(TRIG_ADDR);
      data_o = TRIG_VALUE;
    end else if (step_w == CW'(0)) begin
      data_o = NO_HDR_BYTES;
    end else if (step_w == CW'(1)) begin
      data_o = 8'(len_i);
    end
  end
endmodule

// File: rtl/tfl_ctrl.sv
module tfl_ctrl
  import tfl_pkg::*;
#(
  parameter int unsigned LEN_W  = 7,
  parameter int unsigned STEP_W = 7
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start_i,
  input  logic [LEN_W-1:0]      len_i,
  input  logic                  ack_i,
  input  logic                  dec_long_i,
  input  logic [REG_ADDR_W-1:0] dec_addr_i,
  input  logic [7:0]            dec_data_i,
  input  logic                  dec_last_i,
  output logic [STEP_W-1:0]     step_o,
  output logic [LEN_W-1:0]      len_o,
  output logic [LEN_W-1:0]      rd_addr_o,
  output logic                  req_o,
  output logic                  req_long_o,
  output logic [REG_ADDR_W-1:0] req_addr_o,
  output logic [7:0]            req_data_o,
  output logic                  done_o
);
  localparam int unsigned CW = STEP_W + 1;

  tfl_state_e state_q;
  logic       last_q;
  logic       idx_ok;
  logic [CW-1:0] nxt_idx;

  // index of the payload byte needed by step_o+1
  assign nxt_idx = CW'(step_o) - CW'(1);
  assign idx_ok  = (step_o != '0) && (nxt_idx < CW'(len_o));

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      step_o     <= '0;
      len_o      <= '0;
      rd_addr_o  <= '0;
      req_o      <= 1'b0;
      req_long_o <= 1'b0;
      req_addr_o <= '0;
      req_data_o <= '0;
      last_q     <= 1'b0;
      done_o     <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            len_o     <= len_i;
            step_o    <= '0;
            rd_addr_o <= '0;
            state_q   <= ST_FETCH;
          end
        end
        ST_FETCH: state_q <= ST_LOAD;   // buffer read in flight
        ST_LOAD: begin
          req_o      <= 1'b1;
          req_long_o <= dec_long_i;
          req_addr_o <= dec_addr_i;
          req_data_o <= dec_data_i;
          last_q     <= dec_last_i;
          state_q    <= ST_WAIT;
        end
        ST_WAIT: begin
          if (ack_i) begin
            req_o <= 1'b0;
            if (last_q) begin
              done_o  <= 1'b1;
              state_q <= ST_IDLE;
            end else begin
              step_o    <= step_o + 1'b1;
              rd_addr_o <= idx_ok ? LEN_W'(nxt_idx) : '0;
              state_q   <= ST_FETCH;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  p_req_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (req_o && !ack_i) |=> (req_o && $stable(req_addr_o) && $stable(req_data_o) && $stable(req_long_o)));

  p_req_drop_r6: assert property (@(posedge clk) disable iff (rst)
    (req_o && ack_i) |=> !req_o);

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  p_done_cause_r7: assert property (@(posedge clk) disable iff (rst)
    done_o |-> $past(req_o && ack_i && !req_long_o));

  p_trigger_fields_r5: assert property (@(posedge clk) disable iff (rst)
    (req_o && !req_long_o) |-> (req_addr_o == REG_ADDR_W'(TRIG_ADDR) && req_data_o == TRIG_VALUE));

  p_no_restart_r9: assert property (@(posedge clk) disable iff (rst)
    (state_q != ST_IDLE) |=> !(state_q == ST_FETCH && step_o == '0 && !$past(ack_i)));

  p_len_stable_r9: assert property (@(posedge clk) disable iff (rst)
    (state_q != ST_IDLE) |=> $stable(len_o));
endmodule

// File: rtl/tx_frame_loader.sv
module tx_frame_loader
  import tfl_pkg::*;
#(
  parameter int unsigned MAX_LEN = 125,
  parameter int unsigned LEN_W   = $clog2(MAX_LEN + 3)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [LEN_W-1:0] len_i,
  output logic [LEN_W-1:0] rd_addr_o,
  input  logic [7:0]       rd_data_i,
  output logic             req_o,
  output logic             req_long_o,
  output logic [9:0]       req_addr_o,
  output logic [7:0]       req_data_o,
  input  logic             ack_i,
  output logic             done_o
);
  localparam int unsigned STEP_W = $clog2(MAX_LEN + 3);

  initial begin
    assert (MAX_LEN + 2 < (1 << REG_ADDR_W))
      else $error("MAX_LEN does not fit the long address space");
    assert (LEN_W <= STEP_W && MAX_LEN < (1 << LEN_W))
      else $error("LEN_W inconsistent with MAX_LEN");
  end

  logic [LEN_W-1:0]      len_clamped;
  logic [LEN_W-1:0]      len_q;
  logic [STEP_W-1:0]     step_q;
  logic                  dec_long;
  logic [REG_ADDR_W-1:0] dec_addr;
  logic [7:0]            dec_data;
  logic                  dec_last;

  assign len_clamped = (len_i > LEN_W'(MAX_LEN)) ? LEN_W'(MAX_LEN) : len_i;

  tfl_step_decode #(.LEN_W(LEN_W), .STEP_W(STEP_W)) u_dec (
    .step_i (step_q),
    .len_i  (len_q),
    .byte_i (rd_data_i),
    .long_o (dec_long),
    .addr_o (dec_addr),
    .data_o (dec_data),
    .last_o (dec_last)
  );

  tfl_ctrl #(.LEN_W(LEN_W), .STEP_W(STEP_W)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start_i),
    .len_i      (len_clamped),
    .ack_i      (ack_i),
    .dec_long_i (dec_long),
    .dec_addr_i (dec_addr),
    .dec_data_i (dec_data),
    .dec_last_i (dec_last),
    .step_o     (step_q),
    .len_o      (len_q),
    .rd_addr_o  (rd_addr_o),
    .req_o      (req_o),
    .req_long_o (req_long_o),
    .req_addr_o (req_addr_o),
    .req_data_o (req_data_o),
    .done_o     (done_o)
  );

  p_len_bound_r10: assert property (@(posedge clk) disable iff (rst)
    (req_o && req_long_o && req_addr_o == 10'h001) |-> (req_data_o <= 8'(MAX_LEN)));

  p_payload_index_r4: assert property (@(posedge clk) disable iff (rst)
    (req_o && req_long_o && req_addr_o >= 10'h002) |-> (req_addr_o - 10'h002 < 10'(len_q)));
endmodule

// File: tb/tb_tx_frame_loader.sv
`timescale 1ns/1ps
module tb_tx_frame_loader;
  localparam int MAX_LEN = 125;
  localparam int LEN_W   = $clog2(MAX_LEN + 3);

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             start_i = 1'b0;
  logic [LEN_W-1:0] len_i = '0;
  logic [LEN_W-1:0] rd_addr_o;
  logic [7:0]       rd_data_i;
  logic             req_o, req_long_o, ack_i = 1'b0, done_o;
  logic [9:0]       req_addr_o;
  logic [7:0]       req_data_o;

  always #5 clk = ~clk;

  tx_frame_loader #(.MAX_LEN(MAX_LEN)) dut (
    .clk(clk), .rst(rst), .start_i(start_i), .len_i(len_i),
    .rd_addr_o(rd_addr_o), .rd_data_i(rd_data_i),
    .req_o(req_o), .req_long_o(req_long_o), .req_addr_o(req_addr_o),
    .req_data_o(req_data_o), .ack_i(ack_i), .done_o(done_o)
  );

  // payload buffer with one-cycle read latency
  logic [7:0] mem [0:(1<<LEN_W)-1];
  logic [7:0] rd_q;
  always_ff @(posedge clk) rd_q <= mem[rd_addr_o];
  assign rd_data_i = rd_q;

  int n_chk = 0, n_bad = 0;
  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", tag, what, act, exp);
    end
  endtask

  // behavioural reference model
  int    q_lng[$], q_addr[$], q_data[$];
  string q_tag[$];
  bit    busy_m = 0, done_exp = 0, go_req = 0;
  int    wait_cnt = 0, ack_cnt = 0, ack_dly = 0, go_len = 0, writes = 0;

  task automatic build(input int len_req);
    int l = (len_req > MAX_LEN) ? MAX_LEN : len_req;
    string t0 = (l == 0) ? "R8" : "R2";
    q_lng.push_back(1); q_addr.push_back(0); q_data.push_back(0); q_tag.push_back(t0);
    q_lng.push_back(1); q_addr.push_back(1); q_data.push_back(l);
    q_tag.push_back(len_req > MAX_LEN ? "R10" : (l == 0 ? "R8" : "R3"));
    for (int i = 0; i < l; i++) begin
      q_lng.push_back(1); q_addr.push_back(2 + i); q_data.push_back(int'(mem[i]));
      q_tag.push_back(len_req > MAX_LEN ? "R10" : "R4");
    end
    q_lng.push_back(0); q_addr.push_back('h1B); q_data.push_back(1);
    q_tag.push_back(l == 0 ? "R8" : "R5");
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      bit exp_req, was_busy;
      was_busy = busy_m;
      if (wait_cnt > 0) wait_cnt--;
      exp_req = busy_m && (wait_cnt == 0);
      chk(req_o == exp_req, "R6", "req_o timing", req_o, exp_req);
      chk(done_o == done_exp, "R7", "done_o", done_o, done_exp);
      done_exp = 0;
      start_i = 0;
      ack_i   = 0;
      if (req_o && exp_req) begin
        if (ack_cnt >= ack_dly) begin
          ack_i = 1; ack_cnt = 0; writes++;
          if (q_lng.size() == 0) chk(0, "R9", "write with empty model queue", 0, 1);
          else begin
            int el, ea, ed; string tg;
            el = q_lng.pop_front(); ea = q_addr.pop_front();
            ed = q_data.pop_front(); tg = q_tag.pop_front();
            chk(req_long_o == el[0], tg, "address space", req_long_o, el);
            chk(int'(req_addr_o) == ea, tg, "address", req_addr_o, ea);
            chk(int'(req_data_o) == ed, tg, "data", req_data_o, ed);
            if (q_lng.size() == 0) begin busy_m = 0; done_exp = 1; end
            else wait_cnt = 3;
          end
        end else ack_cnt++;
      end
      if (go_req) begin
        start_i = 1; len_i = LEN_W'(go_len); go_req = 0;
        if (!was_busy) begin busy_m = 1; wait_cnt = 3; ack_cnt = 0; writes = 0; build(go_len); end
      end
    end
  end

  task automatic fill(input int seed);
    for (int i = 0; i < (1 << LEN_W); i++) mem[i] = 8'((i * 37 + seed) ^ (seed >> 3));
  endtask

  task automatic run(input int len, input int dly, input int seed, input int busy_len, input string tag);
    int l = (len > MAX_LEN) ? MAX_LEN : len;
    fill(seed);
    @(posedge clk); #1;
    ack_dly = dly; go_len = len; go_req = 1;
    wait (go_req == 0);
    if (busy_len >= 0) begin
      repeat (6) @(posedge clk); #1;
      go_len = busy_len; go_req = 1;
      wait (go_req == 0);
    end
    wait (busy_m == 0);
    repeat (2) @(negedge clk);
    chk(writes == l + 3, tag, "write count", writes, l + 3);
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      chk(0, "R6", "watchdog expired", cyc, 150000);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(req_o == 0, "R1", "req_o in reset", req_o, 0);
    chk(done_o == 0, "R1", "done_o in reset", done_o, 0);
    chk(rd_addr_o == 0, "R1", "rd_addr_o in reset", rd_addr_o, 0);
    @(posedge clk); #1 rst = 0;
    @(negedge clk);
    chk(req_o == 0 && done_o == 0 && rd_addr_o == 0, "R1", "outputs after reset", req_o, 0);

    run(3, 0, 11, -1, "R4");
    run(0, 2, 5, -1, "R8");
    run(5, 1, 90, 9, "R9");      // second start while busy must be dropped
    run(1, 3, 200, -1, "R4");
    run(MAX_LEN, 0, 17, -1, "R4");
    run((1 << LEN_W) - 1, 1, 63, -1, "R10");
    // back-to-back: start issued in the done cycle
    fill(44);
    @(posedge clk); #1; ack_dly = 0; go_len = 2; go_req = 1;
    wait (go_req == 0); wait (busy_m == 0);
    @(posedge clk); #1; go_len = 4; go_req = 1;
    wait (go_req == 0); wait (busy_m == 0);
    repeat (2) @(negedge clk);
    chk(writes == 7, "R7", "restart after done", writes, 7);
    chk(q_lng.size() == 0, "R5", "model queue drained", q_lng.size(), 0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule